// File: doc/BRIEF.md
# Scaler Phase Stepper

This block is the control core for one axis of a two-dimensional image scaler. A request carries a source length in Q16 fixed point, an integer destination length, a chroma subsampling factor for the axis and a flag saying whether the pixel format is chroma-subsampled. The block rejects lengths that are zero or a downscale steeper than 32:1. Otherwise it computes a fixed-point luma phase step, in which 2^21 stands for 1.0, with a sequential restoring divider. It derives the chroma step from the luma step and picks an interpolation filter class for the luma, alpha and chroma components.

Once the step is known, the block emits one item per destination pixel on consecutive cycles. Each item holds an integer source index and a 21-bit fractional phase, taken from an accumulator that starts at zero and grows by the luma step. A separate filter datapath consumes this stream. New requests are taken only while the block is idle.

Top module: `scaler_phase_stepper`

## Requirements
- R1: After reset, `done_o`, `pix_valid_o` and `err_o` are 0 and `luma_step_o` is 0.
- R2: Only bits [LEN_W+15:16] of `src_len_q_i` (the integer part) take part in any decision. Fraction bits [15:0] change no output.
- R3: If the integer source length or `dst_len_i` is zero, `done_o` pulses in the cycle after the start edge with `err_o` = 1 (invalid), and no stream follows.
- R4: If the source length is more than 32 times the destination length, `done_o` pulses in the cycle after the start edge with `err_o` = 2 (overflow), and no stream follows. A ratio of exactly 32 is accepted and gives a step of 2^26.
- R5: An accepted request gives `err_o` = 0 and `luma_step_o` = floor(src × 2^21 / dst). Both appear with a one-cycle `done_o` pulse after LEN_W+21+2 rising edges, counting the edge that samples `start_i` as the first.
- R6: `chroma_step_o` equals `luma_step_o` when `chroma_div2_i` = 0, and floor(`luma_step_o` / 2) when it is 1.
- R7: Starting in the cycle `done_o` rises after a successful request, `pix_valid_o` is high for exactly dst consecutive cycles. Item k (from 0) carries index floor(k·step / 2^21) and phase (k·step) mod 2^21, and `pix_last_o` marks the final item.
- R8: Filter codes are 0 sharp, 1 bilinear, 2 area. If src ≤ dst, `luma_filt_o` = 0 and `alpha_filt_o` = 1. Otherwise both are 2.
- R9: `chroma_filt_o` is 1 when floor(src/2) ≤ dst and 2 otherwise.
- R10: `scale_en_o` is 1 when `csub_fmt_i` = 1, whatever the lengths. When `csub_fmt_i` = 0 it is 1 only if src ≠ dst.
- R11: A `start_i` pulse while a request is being divided or streamed is ignored: it causes no extra `done_o` and leaves the running result and stream unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| src_len_q_i | input | LEN_W+16 | Source length, Q16 fixed point |
| dst_len_i | input | LEN_W | Destination length in pixels |
| chroma_div2_i | input | 1 | Chroma subsampled by 2 on this axis |
| csub_fmt_i | input | 1 | Format is 4:2:0 or horizontally halved |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 2 | 0 none, 1 invalid, 2 overflow |
| luma_step_o | output | STEP_W+1 | Luma phase step, 2^21 = 1.0 |
| chroma_step_o | output | STEP_W+1 | Chroma phase step |
| scale_en_o | output | 1 | Scaling enabled on this axis |
| luma_filt_o | output | 2 | Luma filter class |
| alpha_filt_o | output | 2 | Alpha filter class |
| chroma_filt_o | output | 2 | Chroma filter class |
| pix_valid_o | output | 1 | Stream item valid |
| pix_index_o | output | LEN_W | Source pixel index of the item |
| pix_phase_o | output | 21 | Fractional phase of the item |
| pix_last_o | output | 1 | Final item of the stream |

## Verification
The assertions assume that `start_i` is a single-cycle strobe. They also assume that consecutive accepted requests are separated by the divide time, so a stream is always followed by at least one idle cycle before the next `done_o`. The bench respects this by driving each request only after the expected result and all expected stream items have been drained from its scoreboard. Pulses sent in the middle of an operation are there only to show that they are ignored. Operands are chosen so that every accepted ratio lies between 1:2 upscale and exactly 32:1 downscale, which keeps the step within its 27-bit output.

// File: rtl/sps_pkg.sv
// Shared encodings for the scaler phase stepper.
// Assumes: filter and error codes are decoded by neighbouring blocks, so
// their values are fixed.
package sps_pkg;

    typedef enum logic [1:0] {
        FILT_SHARP = 2'd0,
        FILT_BIL   = 2'd1,
        FILT_AREA  = 2'd2
    } sps_filt_t;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_INVALID  = 2'd1,
        ERR_OVERFLOW = 2'd2
    } sps_err_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_STREAM
    } sps_state_t;

endpackage

// File: rtl/sps_divider.sv
// Restoring divider, one quotient bit per cycle, MSB first.
// Assumes: den_i is non-zero and the true quotient fits in Q_W bits; higher
// quotient bits shift out of the register and are lost.
// fin_o pulses in the cycle after the last of NUM_W iterations.
module sps_divider #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 12,
    parameter int Q_W   = 27,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [Q_W-1:0]   quot_o,
    output logic             fin_o
);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] num_sh_q;
    logic [Q_W-1:0]   quot_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fin_q;

    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, num_sh_q[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end

    // Load operands, then run one restoring iteration per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            den_q    <= '0;
            num_sh_q <= '0;
            quot_q   <= '0;
            cnt_q    <= '0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                rem_q    <= '0;
                den_q    <= den_i;
                num_sh_q <= num_i;
                quot_q   <= '0;
                cnt_q    <= CNT_W'(NUM_W);
            end else if (cnt_q != '0) begin
                rem_q    <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                num_sh_q <= num_sh_q << 1;
                quot_q   <= {quot_q[Q_W-2:0], fits};
                cnt_q    <= cnt_q - 1'b1;
                fin_q    <= (cnt_q == CNT_W'(1));
            end
        end
    end

    assign quot_o = quot_q;
    assign fin_o  = fin_q;

endmodule

// File: rtl/sps_filter_pick.sv
// Chooses interpolation filter classes from the scaling direction.
// Assumes: lengths are integer pixel counts; purely combinational.
module sps_filter_pick
    import sps_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [LEN_W-1:0] src_i,
    input  logic [LEN_W-1:0] dst_i,
    output sps_filt_t        luma_o,
    output sps_filt_t        alpha_o,
    output sps_filt_t        chroma_o
);

    // Upscale or unity keeps detail filters; downscale falls back to area.
    always_comb begin
        if (src_i <= dst_i) begin
            luma_o  = FILT_SHARP;
            alpha_o = FILT_BIL;
        end else begin
            luma_o  = FILT_AREA;
            alpha_o = FILT_AREA;
        end
        chroma_o = ((src_i >> 1) <= dst_i) ? FILT_BIL : FILT_AREA;
    end

endmodule

// File: rtl/sps_accum.sv
// Phase accumulator that emits one index/phase item per destination pixel.
// Assumes: count_i is non-zero and stable while active; the integer part of
// the accumulator never exceeds LEN_W bits.
module sps_accum #(
    parameter int LEN_W  = 12,
    parameter int FRAC_W = 21,
    parameter int STEP_W = 26,
    localparam int ACC_W = LEN_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [STEP_W:0]   step_i,
    input  logic [LEN_W-1:0]  count_i,
    output logic              valid_o,
    output logic [LEN_W-1:0]  index_o,
    output logic [FRAC_W-1:0] phase_o,
    output logic              last_o
);

    logic             active_q;
    logic [ACC_W-1:0] acc_q;
    logic [LEN_W-1:0] cnt_q;
    logic             at_end;

    // Final item when the item counter reaches count - 1.
    assign at_end = active_q && (cnt_q == count_i - 1'b1);

    // Clear on load, then add one step per emitted item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (active_q) begin
            acc_q    <= acc_q + ACC_W'(step_i);
            cnt_q    <= cnt_q + 1'b1;
            active_q <= !at_end;
        end
    end

    assign valid_o = active_q;
    assign index_o = acc_q[ACC_W-1:FRAC_W];
    assign phase_o = acc_q[FRAC_W-1:0];
    assign last_o  = at_end;

endmodule

// File: rtl/scaler_phase_stepper.sv
// One-axis scaler control: validates the request, divides for the phase
// step, derives the chroma step and filter classes, then streams per-pixel
// source index and phase.
// Assumes: start_i is a strobe; requests arriving while busy are dropped.
module scaler_phase_stepper
    import sps_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int FRAC_W     = 21,
    parameter int RATIO_LOG2 = 5,
    localparam int STEP_W    = FRAC_W + RATIO_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W+15:0] src_len_q_i,
    input  logic [LEN_W-1:0]  dst_len_i,
    input  logic              chroma_div2_i,
    input  logic              csub_fmt_i,
    output logic              done_o,
    output logic [1:0]        err_o,
    output logic [STEP_W:0]   luma_step_o,
    output logic [STEP_W:0]   chroma_step_o,
    output logic              scale_en_o,
    output logic [1:0]        luma_filt_o,
    output logic [1:0]        alpha_filt_o,
    output logic [1:0]        chroma_filt_o,
    output logic              pix_valid_o,
    output logic [LEN_W-1:0]  pix_index_o,
    output logic [FRAC_W-1:0] pix_phase_o,
    output logic              pix_last_o
);

    localparam int NUM_W = LEN_W + FRAC_W;

    sps_state_t       state_q;
    sps_err_t         err_q;
    logic             done_q;
    logic [STEP_W:0]  luma_q, chroma_q;
    logic             scale_en_q;
    sps_filt_t        luma_f_q, alpha_f_q, chroma_f_q;
    logic [LEN_W-1:0] src_q, dst_q;
    logic             cdiv_q, csub_q;

    logic [LEN_W-1:0] src_int;
    logic             unused_frac;
    logic             len_zero, ratio_ovf, accept, div_load, stream_load;
    logic [STEP_W:0]  quot;
    logic             div_fin;
    sps_filt_t        luma_f, alpha_f, chroma_f;

    // Drop the Q16 fraction; only whole source pixels matter.
    assign src_int     = src_len_q_i[LEN_W+15:16];
    assign unused_frac = ^src_len_q_i[15:0];

    // Request validation against zero lengths and the downscale cap.
    always_comb begin
        len_zero  = (src_int == '0) || (dst_len_i == '0);
        ratio_ovf = {{RATIO_LOG2{1'b0}}, src_int} > {dst_len_i, {RATIO_LOG2{1'b0}}};
        accept    = start_i && (state_q == ST_IDLE);
        div_load  = accept && !len_zero && !ratio_ovf;
        stream_load = (state_q == ST_DIV) && div_fin;
    end

    sps_divider #(
        .NUM_W (NUM_W),
        .DEN_W (LEN_W),
        .Q_W   (STEP_W + 1)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (div_load),
        .num_i  ({src_int, {FRAC_W{1'b0}}}),
        .den_i  (dst_len_i),
        .quot_o (quot),
        .fin_o  (div_fin)
    );

    sps_filter_pick #(
        .LEN_W (LEN_W)
    ) u_filt (
        .src_i    (src_q),
        .dst_i    (dst_q),
        .luma_o   (luma_f),
        .alpha_o  (alpha_f),
        .chroma_o (chroma_f)
    );

    sps_accum #(
        .LEN_W  (LEN_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (stream_load),
        .step_i  (quot),
        .count_i (dst_q),
        .valid_o (pix_valid_o),
        .index_o (pix_index_o),
        .phase_o (pix_phase_o),
        .last_o  (pix_last_o)
    );

    // Sequencing: accept or reject, wait for the divider, publish, stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= ERR_NONE;
            done_q     <= 1'b0;
            luma_q     <= '0;
            chroma_q   <= '0;
            scale_en_q <= 1'b0;
            luma_f_q   <= FILT_SHARP;
            alpha_f_q  <= FILT_SHARP;
            chroma_f_q <= FILT_SHARP;
            src_q      <= '0;
            dst_q      <= '0;
            cdiv_q     <= 1'b0;
            csub_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && len_zero) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_INVALID;
                    end else if (accept && ratio_ovf) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_OVERFLOW;
                    end else if (div_load) begin
                        state_q <= ST_DIV;
                        src_q   <= src_int;
                        dst_q   <= dst_len_i;
                        cdiv_q  <= chroma_div2_i;
                        csub_q  <= csub_fmt_i;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        state_q    <= ST_STREAM;
                        done_q     <= 1'b1;
                        err_q      <= ERR_NONE;
                        luma_q     <= quot;
                        chroma_q   <= cdiv_q ? (quot >> 1) : quot;
                        scale_en_q <= csub_q || (src_q != dst_q);
                        luma_f_q   <= luma_f;
                        alpha_f_q  <= alpha_f;
                        chroma_f_q <= chroma_f;
                    end
                end
                ST_STREAM: begin
                    if (pix_last_o) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o        = done_q;
    assign err_o         = err_q;
    assign luma_step_o   = luma_q;
    assign chroma_step_o = chroma_q;
    assign scale_en_o    = scale_en_q;
    assign luma_filt_o   = luma_f_q;
    assign alpha_filt_o  = alpha_f_q;
    assign chroma_filt_o = chroma_f_q;

endmodule

// File: rtl/scaler_phase_stepper_chk.sv
// Temporal checks on the scaler phase stepper ports, bound to every instance.
// Assumes: start_i is a strobe and consecutive streams are separated by idle
// cycles.
module scaler_phase_stepper_chk #(
    parameter int LEN_W  = 12,
    parameter int STEP_W = 26,
    parameter int FRAC_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [1:0]        err_o,
    input logic [STEP_W:0]   luma_step_o,
    input logic [STEP_W:0]   chroma_step_o,
    input logic [1:0]        luma_filt_o,
    input logic [1:0]        alpha_filt_o,
    input logic [1:0]        chroma_filt_o,
    input logic              pix_valid_o,
    input logic [LEN_W-1:0]  pix_index_o,
    input logic [FRAC_W-1:0] pix_phase_o,
    input logic              pix_last_o
);

    // R5: the result strobe lasts one cycle.
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: an invalid request produces no stream.
    p_invalid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd1) |=> !pix_valid_o);

    // R4: an overflowing request produces no stream.
    p_overflow_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd2) |=> !pix_valid_o);

    // R4: an accepted step never exceeds the 32:1 value and is non-zero.
    p_step_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd0) |->
            (luma_step_o <= (STEP_W+1)'(1) << STEP_W) && (luma_step_o != '0));

    // R6: the chroma step lies between half the luma step and the luma step.
    p_chroma_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd0) |->
            (chroma_step_o <= luma_step_o) && (chroma_step_o >= (luma_step_o >> 1)));

    // R7: the stream starts together with the success pulse at position zero.
    p_stream_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid_o) |-> (done_o && pix_index_o == '0 && pix_phase_o == '0));

    // R7: items are contiguous until the last one.
    p_stream_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && !pix_last_o) |=> pix_valid_o);

    // R7: source index never moves backwards within a stream.
    p_index_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && $past(pix_valid_o)) |-> (pix_index_o >= $past(pix_index_o)));

    // R8: sharp luma implies bilinear alpha; area luma implies area alpha.
    p_alpha_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd0) |->
            ((luma_filt_o == 2'd0) ? (alpha_filt_o == 2'd1) : (alpha_filt_o == 2'd2)));

    // R9: a non-downscaling axis always gets bilinear chroma.
    p_chroma_filt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd0 && luma_filt_o == 2'd0) |-> (chroma_filt_o == 2'd1));

endmodule

bind scaler_phase_stepper scaler_phase_stepper_chk #(
    .LEN_W  (LEN_W),
    .STEP_W (STEP_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done_o        (done_o),
    .err_o         (err_o),
    .luma_step_o   (luma_step_o),
    .chroma_step_o (chroma_step_o),
    .luma_filt_o   (luma_filt_o),
    .alpha_filt_o  (alpha_filt_o),
    .chroma_filt_o (chroma_filt_o),
    .pix_valid_o   (pix_valid_o),
    .pix_index_o   (pix_index_o),
    .pix_phase_o   (pix_phase_o),
    .pix_last_o    (pix_last_o)
);

// File: tb/test_scaler_phase_stepper.sv
// Scoreboard bench: the driver pushes expected results and stream items,
// and a negedge monitor pops and compares them as the design emits them.
module test_scaler_phase_stepper;

    localparam int LEN_W  = 12;
    localparam int FRAC_W = 21;
    localparam int STEP_W = 26;
    localparam int LAT_OK = LEN_W + FRAC_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W+15:0] src_len_q_i = '0;
    logic [LEN_W-1:0]  dst_len_i = '0;
    logic              chroma_div2_i = 1'b0;
    logic              csub_fmt_i = 1'b0;
    logic              done_o;
    logic [1:0]        err_o;
    logic [STEP_W:0]   luma_step_o, chroma_step_o;
    logic              scale_en_o;
    logic [1:0]        luma_filt_o, alpha_filt_o, chroma_filt_o;
    logic              pix_valid_o;
    logic [LEN_W-1:0]  pix_index_o;
    logic [FRAC_W-1:0] pix_phase_o;
    logic              pix_last_o;

    scaler_phase_stepper i_scaler_phase_stepper (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_len_q_i(src_len_q_i), .dst_len_i(dst_len_i),
        .chroma_div2_i(chroma_div2_i), .csub_fmt_i(csub_fmt_i),
        .done_o(done_o), .err_o(err_o),
        .luma_step_o(luma_step_o), .chroma_step_o(chroma_step_o),
        .scale_en_o(scale_en_o), .luma_filt_o(luma_filt_o),
        .alpha_filt_o(alpha_filt_o), .chroma_filt_o(chroma_filt_o),
        .pix_valid_o(pix_valid_o), .pix_index_o(pix_index_o),
        .pix_phase_o(pix_phase_o), .pix_last_o(pix_last_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int     err;
        longint step;
        longint cstep;
        int     lf, af, cf, se;
        longint due;
        string  tag;
    } res_t;

    typedef struct {
        longint idx;
        longint ph;
        int     last;
    } pix_t;

    res_t   res_q[$];
    pix_t   pix_q[$];
    int     n_chk = 0;
    int     n_bad = 0;
    int     n_unexp = 0;
    longint cyc = 0;
    bit     mon_on = 1'b0;
    bit     ended = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Monitor: compare each result pulse and stream item with the scoreboard.
    always @(negedge clk) begin
        res_t r;
        pix_t p;
        if (mon_on) begin
            if (done_o) begin
                if (res_q.size() == 0) begin
                    n_unexp++;
                    chk(1'b0, "R11 spurious done", 1, 0);
                end else begin
                    r = res_q.pop_front();
                    chk(cyc == r.due, {r.tag, " latency"}, cyc, r.due);
                    chk(err_o == r.err, {r.tag, " err"}, err_o, r.err);
                    if (r.err == 0) begin
                        chk(luma_step_o == r.step, {r.tag, " R5 luma step"}, luma_step_o, r.step);
                        chk(chroma_step_o == r.cstep, "R6 chroma step", chroma_step_o, r.cstep);
                        chk(luma_filt_o == r.lf, "R8 luma filter", luma_filt_o, r.lf);
                        chk(alpha_filt_o == r.af, "R8 alpha filter", alpha_filt_o, r.af);
                        chk(chroma_filt_o == r.cf, "R9 chroma filter", chroma_filt_o, r.cf);
                        chk(scale_en_o == r.se, "R10 scale enable", scale_en_o, r.se);
                    end
                end
            end
            if (pix_valid_o) begin
                if (pix_q.size() == 0) begin
                    n_unexp++;
                    chk(1'b0, "R11 spurious item", 1, 0);
                end else begin
                    p = pix_q.pop_front();
                    chk(pix_index_o == p.idx, "R7 index", pix_index_o, p.idx);
                    chk(pix_phase_o == p.ph, "R7 phase", pix_phase_o, p.ph);
                    chk(pix_last_o == p.last, "R7 last", pix_last_o, p.last);
                end
            end
        end
    end

    // Driver: compute expectations, push them, pulse start, optionally
    // disturb with a second start (mode 1 during divide, 2 during stream).
    task automatic run_op(input int src, input int frac, input int dst,
                          input int cdiv, input int csub, input int disturb,
                          input string tag);
        res_t   r;
        longint step;
        step = 0;
        if (src == 0 || dst == 0) r.err = 1;
        else if (src > 32 * dst) r.err = 2;
        else r.err = 0;
        if (r.err == 0) step = (longint'(src) << FRAC_W) / dst;
        r.step  = step;
        r.cstep = cdiv ? step / 2 : step;
        r.lf    = (src <= dst) ? 0 : 2;
        r.af    = (src <= dst) ? 1 : 2;
        r.cf    = ((src / 2) <= dst) ? 1 : 2;
        r.se    = (csub != 0 || src != dst) ? 1 : 0;
        r.tag   = tag;
        @(negedge clk);
        r.due = cyc + ((r.err == 0) ? LAT_OK : 1);
        res_q.push_back(r);
        if (r.err == 0) begin
            for (int k = 0; k < dst; k++) begin
                pix_t p;
                longint a;
                a      = longint'(k) * step;
                p.idx  = a >> FRAC_W;
                p.ph   = a & ((longint'(1) << FRAC_W) - 1);
                p.last = (k == dst - 1) ? 1 : 0;
                pix_q.push_back(p);
            end
        end
        src_len_q_i   = (LEN_W+16)'((longint'(src) << 16) | frac);
        dst_len_i     = LEN_W'(dst);
        chroma_div2_i = cdiv[0];
        csub_fmt_i    = csub[0];
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb == 1) begin
            repeat (5) @(negedge clk);
        end else if (disturb == 2) begin
            while (!pix_valid_o) @(negedge clk);
            @(negedge clk);
        end
        if (disturb != 0) begin
            src_len_q_i = (LEN_W+16)'(longint'(50) << 16);
            dst_len_i   = LEN_W'(1);
            start_i     = 1'b1;
            @(negedge clk);
            start_i     = 1'b0;
            src_len_q_i = (LEN_W+16)'((longint'(src) << 16) | frac);
            dst_len_i   = LEN_W'(dst);
        end
        while (res_q.size() != 0 || pix_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(pix_valid_o == 1'b0, "R1 valid", pix_valid_o, 0);
        chk(err_o == 2'd0, "R1 err", err_o, 0);
        chk(luma_step_o == '0, "R1 step", luma_step_o, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        run_op(100, 0, 100, 0, 0, 0, "R5 unity");
        run_op(100, 16'hFFFF, 100, 0, 0, 0, "R2 fraction ignored");
        run_op(0, 16'h8000, 10, 0, 0, 0, "R2 R3 fraction only");
        run_op(0, 0, 10, 0, 0, 0, "R3 zero source");
        run_op(10, 0, 0, 0, 0, 0, "R3 zero destination");
        run_op(640, 0, 1280, 1, 0, 0, "R5 upscale");
        run_op(300, 0, 100, 1, 1, 0, "R5 downscale 3x");
        run_op(150, 0, 100, 0, 0, 0, "R5 downscale 1.5x");
        run_op(7, 0, 3, 1, 0, 0, "R5 inexact");
        run_op(3200, 0, 100, 0, 0, 0, "R4 exact 32x");
        run_op(3201, 0, 100, 0, 0, 0, "R4 over 32x");
        run_op(64, 0, 64, 1, 1, 0, "R10 subsampled unity");
        run_op(10, 0, 20, 0, 0, 1, "R11 start while dividing");
        run_op(30, 0, 20, 0, 1, 2, "R11 start while streaming");
        chk(n_unexp == 0, "R11 no extra output", n_unexp, 0);

        finish_run();
    end

endmodule